// File: doc/BRIEF.md
# Register-Write Command List Executor

This block runs a list of register-write instructions that software has built in a word-addressed memory and applies them on a small register bus. Software first sets an enable bit and loads a head pointer. It then writes a tail pointer, and that write starts execution. The engine reads 32-bit words one at a time, from the head up to, but not including, the tail. It decodes each instruction and turns it into one or more bus writes. While it runs it raises a busy flag.

Two instruction kinds exist, and every instruction starts on an even word. A direct write is two words: the value, then a command word. An indexed burst is a count word N, a command word, and then N values. All N values go to one register offset. When a burst ends on an odd word, one zero word follows it so that the next instruction starts on an even word. A zero command word is a no-op. Software therefore fills the space up to the line-aligned tail with zeros. A command word with any other opcode marks a sticky error and stops the run.

The block has no read instructions. It does no address translation and has no cache.

Top module: `cmdlist_exec`

## Requirements
- R1: After reset, busy, err, wr_valid and mem_re are all low.
- R2: A tail write (cfg_sel=2) starts a run when enable is set, the engine is idle and the new tail differs from head. Busy is high in the cycle after that write. Fetching begins at the head word address (byte address bits 2 and below ignored) and stops before the tail word address (byte address bits 5:0 ignored, so the tail sits on a 64-byte line).
- R3: A tail write while enable (control bit 0) is low is ignored: busy stays low and no word is fetched.
- R4: A command word with opcode 0x01 in bits 31:24 causes one bus write. Its data is the word just before the command word, its byte enables are command bits 23:20, and its offset is command bits 19:0.
- R5: A command word with opcode 0x09 causes N bus writes, where N is the word just before it. The values are the N words that follow the command word, written in list order, all to offset bits 19:0 and all with byte enables 4'hF.
- R6: After a burst with odd N, the next word is padding and is skipped. The next instruction starts at the following even word.
- R7: A command word with opcode 0x00 consumes its word pair and produces no bus write.
- R8: Any other opcode produces no bus write, sets err, and ends the run in the same cycle that err rises. Err stays set until a control write with bit 1 set clears it.
- R9: Once wr_valid is high, wr_valid, wr_offset, wr_data and wr_be hold steady until wr_ready is seen. No memory read is issued while a write is pending.
- R10: Writes to head or tail while busy have no effect. Busy falls once the last word before the tail has been consumed and its write, if any, has been accepted.
- R11: A burst with N=0 produces no bus write, and the next instruction follows directly after the command word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 head, 2 tail |
| cfg_wdata | input | 32 | Configuration write data (byte addresses for the pointers) |
| busy | output | 1 | High while a list is being executed |
| err | output | 1 | Sticky flag for an unknown opcode |
| mem_re | output | 1 | Memory read strobe; data is expected in the next cycle |
| mem_addr | output | ADDR_W | Word address of the read |
| mem_rdata | input | 32 | Read data, one cycle after mem_re |
| wr_valid | output | 1 | Register-bus write request |
| wr_ready | input | 1 | Register-bus accept |
| wr_offset | output | 20 | Target register offset |
| wr_be | output | 4 | Byte enables |
| wr_data | output | 32 | Write data |

## Verification
Two things can happen in the same cycle: a register-bus write can sit stalled, and software can rewrite the head and tail. To provoke this, the bench holds wr_ready low three cycles out of four. While the run is in progress it then writes a larger tail and a different head. Just past the original tail it places a valid direct write that would run only if the tail change took effect. The bench judges the outcome by counting the writes that reach the bus, and then by restarting with a tail write alone to confirm that the head kept its first value.

// File: rtl/cmdlist_pkg.sv
package cmdlist_pkg;
    localparam int WORD_W = 32;
    localparam int OFF_W  = 20;
    localparam int BE_W   = 4;

    localparam logic [7:0] OPC_NOP    = 8'h00;
    localparam logic [7:0] OPC_DIRECT = 8'h01;
    localparam logic [7:0] OPC_BURST  = 8'h09;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_HEAD = 2'd1;
    localparam logic [1:0] SEL_TAIL = 2'd2;

    typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EVAL, ST_WRITE} seq_state_e;
    typedef enum logic [1:0] {PH_LEAD, PH_CMD, PH_DATA, PH_PAD} phase_e;
    typedef enum logic [1:0] {K_NOP, K_DIRECT, K_BURST, K_BAD} cmd_kind_e;

    typedef struct packed {
        cmd_kind_e              kind;
        logic [BE_W-1:0]        be;
        logic [OFF_W-1:0]       off;
    } cmd_t;
endpackage

// File: rtl/cmdlist_decode.sv
module cmdlist_decode
    import cmdlist_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output cmd_t              cmd
);
    always_comb begin
        cmd.be  = word[23:20];
        cmd.off = word[OFF_W-1:0];
        case (word[31:24])
            OPC_NOP:    cmd.kind = K_NOP;
            OPC_DIRECT: cmd.kind = K_DIRECT;
            OPC_BURST:  cmd.kind = K_BURST;
            default:    cmd.kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/cmdlist_regs.sv
module cmdlist_regs
    import cmdlist_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int LINE_WORDS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              busy,
    input  logic              abort,
    output logic              enable,
    output logic              err,
    output logic              start,
    output logic [ADDR_W-1:0] start_head,
    output logic [ADDR_W-1:0] start_tail
);
    localparam int LINE_LSB = $clog2(LINE_WORDS);

    typedef struct packed {
        logic              enable;
        logic              err;
        logic [ADDR_W-1:0] head;
    } regs_t;

    regs_t r_q, r_d;
    logic [ADDR_W-1:0] wr_word;
    logic [ADDR_W-1:0] tail_aligned;
    logic [ADDR_W-1:0] head_aligned;

    assign wr_word      = cfg_wdata[ADDR_W+1:2];
    assign tail_aligned = {wr_word[ADDR_W-1:LINE_LSB], {LINE_LSB{1'b0}}};
    assign head_aligned = {wr_word[ADDR_W-1:1], 1'b0};

    always_comb begin
        r_d   = r_q;
        start = 1'b0;
        if (cfg_we) begin
            case (cfg_sel)
                SEL_CTRL: begin
                    r_d.enable = cfg_wdata[0];
                    if (cfg_wdata[1]) r_d.err = 1'b0;
                end
                SEL_HEAD: if (!busy) r_d.head = head_aligned;
                SEL_TAIL: if (!busy && r_q.enable && tail_aligned != r_q.head) start = 1'b1;
                default: ;
            endcase
        end
        if (abort) r_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign enable     = r_q.enable;
    assign err        = r_q.err;
    assign start_head = r_q.head;
    assign start_tail = tail_aligned;
endmodule

// File: rtl/cmdlist_seq.sv
module cmdlist_seq
    import cmdlist_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_head,
    input  logic [ADDR_W-1:0] start_tail,
    output logic              busy,
    output logic              abort,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [OFF_W-1:0]  wr_offset,
    output logic [BE_W-1:0]   wr_be,
    output logic [WORD_W-1:0] wr_data
);
    typedef struct packed {
        seq_state_e        st;
        phase_e            ph;
        logic [ADDR_W-1:0] ptr;
        logic [ADDR_W-1:0] last;
        logic [WORD_W-1:0] hold;
        logic [WORD_W-1:0] remain;
        logic              pad;
        logic [OFF_W-1:0]  boff;
        logic              wv;
        logic [OFF_W-1:0]  woff;
        logic [BE_W-1:0]   wbe;
        logic [WORD_W-1:0] wdat;
    } seq_t;

    seq_t s_q, s_d;
    cmd_t cmd;
    logic [ADDR_W-1:0] ptr_inc;
    logic              issue;
    logic              bad;

    cmdlist_decode u_dec (.word(mem_rdata), .cmd(cmd));

    assign ptr_inc = s_q.ptr + 1'b1;

    always_comb begin
        s_d   = s_q;
        issue = 1'b0;
        bad   = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.ptr  = start_head;
                    s_d.last = start_tail;
                    s_d.ph   = PH_LEAD;
                    s_d.st   = ST_FETCH;
                end
            end
            ST_FETCH: s_d.st = ST_EVAL;
            ST_EVAL: begin
                s_d.ptr = ptr_inc;
                case (s_q.ph)
                    PH_LEAD: begin
                        s_d.hold = mem_rdata;
                        s_d.ph   = PH_CMD;
                    end
                    PH_CMD: begin
                        s_d.ph = PH_LEAD;
                        case (cmd.kind)
                            K_DIRECT: begin
                                issue    = 1'b1;
                                s_d.wdat = s_q.hold;
                                s_d.woff = cmd.off;
                                s_d.wbe  = cmd.be;
                            end
                            K_BURST: begin
                                s_d.boff = cmd.off;
                                if (s_q.hold != '0) begin
                                    s_d.remain = s_q.hold;
                                    s_d.pad    = s_q.hold[0];
                                    s_d.ph     = PH_DATA;
                                end
                            end
                            K_BAD:   bad = 1'b1;
                            default: ;
                        endcase
                    end
                    PH_DATA: begin
                        issue      = 1'b1;
                        s_d.wdat   = mem_rdata;
                        s_d.woff   = s_q.boff;
                        s_d.wbe    = '1;
                        s_d.remain = s_q.remain - 1'b1;
                        if (s_q.remain == 'd1) s_d.ph = s_q.pad ? PH_PAD : PH_LEAD;
                    end
                    default: s_d.ph = PH_LEAD;
                endcase
                if (bad) begin
                    s_d.st = ST_IDLE;
                end else if (issue) begin
                    s_d.wv = 1'b1;
                    s_d.st = ST_WRITE;
                end else begin
                    s_d.st = (ptr_inc == s_q.last) ? ST_IDLE : ST_FETCH;
                end
            end
            ST_WRITE: begin
                if (wr_ready) begin
                    s_d.wv = 1'b0;
                    s_d.st = (s_q.ptr == s_q.last) ? ST_IDLE : ST_FETCH;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy      = (s_q.st != ST_IDLE);
    assign abort     = bad;
    assign mem_re    = (s_q.st == ST_FETCH);
    assign mem_addr  = s_q.ptr;
    assign wr_valid  = s_q.wv;
    assign wr_offset = s_q.woff;
    assign wr_be     = s_q.wbe;
    assign wr_data   = s_q.wdat;
endmodule

// File: rtl/cmdlist_exec.sv
module cmdlist_exec
    import cmdlist_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int LINE_WORDS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic              busy,
    output logic              err,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [31:0]       mem_rdata,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [19:0]       wr_offset,
    output logic [3:0]        wr_be,
    output logic [31:0]       wr_data
);
    logic              enable_w;
    logic              start_w;
    logic              abort_w;
    logic [ADDR_W-1:0] head_w;
    logic [ADDR_W-1:0] tail_w;

    cmdlist_regs #(.ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .busy       (busy),
        .abort      (abort_w),
        .enable     (enable_w),
        .err        (err),
        .start      (start_w),
        .start_head (head_w),
        .start_tail (tail_w)
    );

    cmdlist_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_w),
        .start_head (head_w),
        .start_tail (tail_w),
        .busy       (busy),
        .abort      (abort_w),
        .mem_re     (mem_re),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .wr_valid   (wr_valid),
        .wr_ready   (wr_ready),
        .wr_offset  (wr_offset),
        .wr_be      (wr_be),
        .wr_data    (wr_data)
    );
endmodule

// File: rtl/cmdlist_exec_chk.sv
module cmdlist_exec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [1:0]  cfg_sel,
    input logic [31:0] cfg_wdata,
    input logic        enable,
    input logic        busy,
    input logic        err,
    input logic        mem_re,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic [19:0] wr_offset,
    input logic [3:0]  wr_be,
    input logic [31:0] wr_data
);
    // R1 / R10: nothing is requested on either bus when idle
    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!wr_valid && !mem_re));

    a_r9_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_offset) && $stable(wr_data) && $stable(wr_be)));

    a_r9_no_fetch_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !mem_re);

    a_r8_abort_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !busy);

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(cfg_we && cfg_sel == 2'd0 && cfg_wdata[1])) |=> err);

    a_r3_disabled_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == 2'd2 && !enable && !busy) |=> !busy);
endmodule

bind cmdlist_exec cmdlist_exec_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .enable    (enable_w),
    .busy      (busy),
    .err       (err),
    .mem_re    (mem_re),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_offset (wr_offset),
    .wr_be     (wr_be),
    .wr_data   (wr_data)
);

// File: tb/cmdlist_exec_test.sv
module cmdlist_exec_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_sel = 2'd0;
    logic [31:0]       cfg_wdata = '0;
    logic              busy, err, mem_re, wr_valid;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0]       mem_rdata = '0;
    logic              wr_ready = 1'b1;
    logic [19:0]       wr_offset;
    logic [3:0]        wr_be;
    logic [31:0]       wr_data;

    int checks = 0;
    int failures = 0;

    logic [31:0] mem [0:255];
    logic        stall_mode = 1'b0;
    logic [1:0]  rcnt = '0;

    int          nlog = 0;
    logic [19:0] log_off  [0:31];
    logic [3:0]  log_be   [0:31];
    logic [31:0] log_data [0:31];
    int          nfetch = 0;
    logic [ADDR_W-1:0] first_fetch = '0;

    int          nexp = 0;
    logic [19:0] exp_off  [0:31];
    logic [3:0]  exp_be   [0:31];
    logic [31:0] exp_data [0:31];

    cmdlist_exec uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .busy(busy), .err(err), .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_offset(wr_offset), .wr_be(wr_be),
        .wr_data(wr_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
        rcnt     <= rcnt + 1'b1;
        wr_ready <= stall_mode ? (rcnt == 2'b11) : 1'b1;
    end

    always @(negedge clk) begin
        if (wr_valid && wr_ready && nlog < 32) begin
            log_off[nlog]  = wr_offset;
            log_be[nlog]   = wr_be;
            log_data[nlog] = wr_data;
            nlog++;
        end
        if (mem_re) begin
            if (nfetch == 0) first_fetch = mem_addr;
            nfetch++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = '0;
        nlog = 0; nfetch = 0; nexp = 0;
    endtask

    task automatic expect_wr(input logic [19:0] off, input logic [3:0] be, input logic [31:0] d);
        exp_off[nexp] = off; exp_be[nexp] = be; exp_data[nexp] = d;
        nexp++;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (busy && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check({req, " run ends"}, {31'd0, busy}, 32'd0);
    endtask

    task automatic compare_log(input string req);
        check({req, " write count"}, nlog, nexp);
        for (int i = 0; i < nexp && i < nlog; i++) begin
            check({req, " offset"}, {12'd0, log_off[i]}, {12'd0, exp_off[i]});
            check({req, " be"}, {28'd0, log_be[i]}, {28'd0, exp_be[i]});
            check({req, " data"}, log_data[i], exp_data[i]);
        end
    endtask

    task automatic t_reset();
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 err", {31'd0, err}, 32'd0);
        check("R1 wr_valid", {31'd0, wr_valid}, 32'd0);
        check("R1 mem_re", {31'd0, mem_re}, 32'd0);
    endtask

    // R2, R4, R7: zero pair first, then two direct writes; unaligned pointers
    task automatic t_direct();
        clear_mem();
        mem[18] = 32'hAAAA5555; mem[19] = 32'h01500123;
        mem[20] = 32'h12345678; mem[21] = 32'h01F3ABCD;
        expect_wr(20'h00123, 4'h5, 32'hAAAA5555);
        expect_wr(20'h3ABCD, 4'hF, 32'h12345678);
        cfg_write(2'd1, 32'h44);
        cfg_write(2'd2, 32'h85);
        check("R2 busy after tail write", {31'd0, busy}, 32'd1);
        wait_idle("R10");
        check("R2 first fetch word", {20'd0, first_fetch}, 32'd16);
        check("R2 fetch count to line tail", nfetch, 16);
        compare_log("R4 R7");
    endtask

    // R5, R6, R11 with a stalling bus (R9)
    task automatic t_indexed();
        clear_mem();
        mem[64] = 3;  mem[65] = 32'h09000200;
        mem[66] = 32'hD1; mem[67] = 32'hD2; mem[68] = 32'hD3; mem[69] = 0;
        mem[70] = 0;  mem[71] = 32'h09000300;
        mem[72] = 2;  mem[73] = 32'h09000400; mem[74] = 32'hE1; mem[75] = 32'hE2;
        mem[76] = 32'hCAFEF00D; mem[77] = 32'h01A00010;
        expect_wr(20'h200, 4'hF, 32'hD1);
        expect_wr(20'h200, 4'hF, 32'hD2);
        expect_wr(20'h200, 4'hF, 32'hD3);
        expect_wr(20'h400, 4'hF, 32'hE1);
        expect_wr(20'h400, 4'hF, 32'hE2);
        expect_wr(20'h010, 4'hA, 32'hCAFEF00D);
        stall_mode = 1'b1;
        cfg_write(2'd1, 32'h100);
        cfg_write(2'd2, 32'h140);
        wait_idle("R9");
        stall_mode = 1'b0;
        compare_log("R5 R6 R11");
    endtask

    task automatic t_disabled();
        clear_mem();
        mem[1] = 32'h01F00001;
        cfg_write(2'd0, 32'h0);
        cfg_write(2'd1, 32'h0);
        cfg_write(2'd2, 32'h40);
        repeat (10) @(negedge clk);
        check("R3 busy stays low", {31'd0, busy}, 32'd0);
        check("R3 no fetch", nfetch, 0);
        check("R3 no write", nlog, 0);
        cfg_write(2'd0, 32'h1);
    endtask

    task automatic t_error();
        clear_mem();
        mem[1] = 32'h07000000;
        mem[2] = 32'h55; mem[3] = 32'h01F00070;
        cfg_write(2'd1, 32'h0);
        cfg_write(2'd2, 32'h40);
        wait_idle("R8");
        check("R8 err set", {31'd0, err}, 32'd1);
        check("R8 no write", nlog, 0);
        check("R8 stopped early", nfetch, 2);
        repeat (3) @(negedge clk);
        check("R8 err sticky", {31'd0, err}, 32'd1);
        cfg_write(2'd0, 32'h3);
        check("R8 err cleared", {31'd0, err}, 32'd0);
    endtask

    task automatic t_busy_rewrite();
        clear_mem();
        mem[128] = 32'h0BADBEEF; mem[129] = 32'h01F00050;
        mem[144] = 32'h0000DEAD; mem[145] = 32'h01F00060;
        expect_wr(20'h50, 4'hF, 32'h0BADBEEF);
        stall_mode = 1'b1;
        cfg_write(2'd1, 32'h200);
        cfg_write(2'd2, 32'h240);
        check("R10 busy", {31'd0, busy}, 32'd1);
        cfg_write(2'd2, 32'h3C0);
        cfg_write(2'd1, 32'h000);
        wait_idle("R10");
        check("R10 fetch count unchanged", nfetch, 16);
        compare_log("R10 tail rewrite ignored");
        nlog = 0; nfetch = 0;
        cfg_write(2'd2, 32'h240);
        wait_idle("R10");
        check("R10 head kept first value", {20'd0, first_fetch}, 32'd128);
        compare_log("R10 head rewrite ignored");
        stall_mode = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        cfg_write(2'd0, 32'h1);
        t_direct();
        t_indexed();
        t_disabled();
        t_error();
        t_busy_rewrite();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule